// File: doc/BRIEF.md
# Masked CAM Command Register File

This block sits at the front of a 32-bit content-addressable memory and carries out its control-state commands. It holds a configuration word, a device select word, a comparand, seven mask words, an address pointer and a 16-entry word store in which every entry has its own valid flag. Each cycle a command may arrive as a 12-bit opcode, an active-low write strobe and a 32-bit data word. The strobe sets the direction of the command. The same opcode either writes a register from the data bus or returns it on the read bus. The move opcode either copies the comparand into the addressed store entry or copies that entry back into the comparand.

Every write and every move passes through a bit mask. Opcode bits 8:6 name one of the seven mask words, and code 0 means no mask. A destination bit changes only where the chosen mask bit is 0. Read data is registered and comes out one cycle after the command, marked by a read-valid flag. The address pointer is loaded through its own port, independently of the command.

Top module: `cam_cmd_regfile`

## Requirements
- R1: A synchronous reset clears the configuration, device select, comparand, address pointer, every mask word, every store entry and every valid flag. It also drops the read-valid flag and zeroes the read bus.
- R2: Only opcode bits 5:0 pick the command: 6'b000110 configuration, 6'b000101 comparand, 6'b001000 device select, 6'b001001 mask word, 6'b001100 move, 6'b000111 status. Opcode bits 11:9 have no effect.
- R3: A configuration, comparand or device select write with mask code 0 (opcode bits 8:6) stores the whole data word. With mask code k from 1 to 7, it changes only the bits where mask word k is 0.
- R4: A mask write with code k from 1 to 7 stores the whole data word, unmasked, in mask word k. A mask write with code 0 stores nothing. A mask read with code 0 gives no read output (read-valid stays 0).
- R5: A move with the strobe low writes the comparand into the store entry at the address pointer, under the selected mask. It sets that entry's valid flag to the inverse of the valid input (0 = valid, 1 = empty).
- R6: A move with the strobe high copies the store entry at the address pointer into the comparand, under the selected mask. It gives no read output.
- R7: With the strobe high, a configuration, comparand, device select, status or nonzero-code mask command returns the value it held before that edge. The value appears on the read bus one cycle after the command, with read-valid at 1. In every other cycle read-valid is 0 and the read bus is zero.
- R8: A status read returns the valid flag of the entry at the address pointer in bit 0, with all other bits 0. A status write has no effect.
- R9: A cycle with command-valid low, or with an opcode outside the six codes of R2, changes no register and gives no read output.
- R10: The address load port updates the pointer at the clock edge. A move or status command in the same cycle uses the pointer value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| opcode | input | 12 | Command code: bits 5:0 the command, bits 8:6 the mask code |
| wr_n | input | 1 | Direction strobe: 0 write or move-in, 1 read or move-out |
| data_in | input | 32 | Write data |
| vld_n_in | input | 1 | Valid flag for move-in: 0 valid, 1 empty |
| addr_load | input | 1 | Load the address pointer from addr_in |
| addr_in | input | 4 | New address pointer value |
| rd_data | output | 32 | Registered read data, zero when idle |
| rd_valid | output | 1 | rd_data carries the result of the previous cycle's read |

## Verification
The hardest situation to reach from the ports is a move that overlaps other state changes. An example is a move-in in the same cycle as an address load, followed by a masked move-out whose result is only visible after a later comparand read. The bench builds this with directed sequences. It first loads distinct mask patterns. It then issues a move-in while the pointer is being loaded with a different address, and reads the status of both entries afterwards. Next it changes the comparand and pulls a stored word back through a sparse mask. A long random phase follows, mixing all six commands, both strobe levels, unknown opcodes, random top opcode bits and random pointer loads. A behavioural model is compared against the outputs on every cycle.

// File: rtl/cam_cmd_pkg.sv
package cam_cmd_pkg;

    // Command field codes, opcode bits 5:0
    localparam logic [5:0] FLD_CFG  = 6'b000110;
    localparam logic [5:0] FLD_CMP  = 6'b000101;
    localparam logic [5:0] FLD_DSEL = 6'b001000;
    localparam logic [5:0] FLD_MASK = 6'b001001;
    localparam logic [5:0] FLD_MOVE = 6'b001100;
    localparam logic [5:0] FLD_STAT = 6'b000111;

    localparam int MSEL_LSB = 6;
    localparam int MSEL_W   = 3;

    typedef enum logic [2:0] {
        K_NONE, K_CFG, K_CMP, K_DSEL, K_MASK, K_MOVE, K_STAT
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e         kind;
        logic              is_wr;
        logic [MSEL_W-1:0] msel;
    } cmd_t;

    function automatic cmd_kind_e kind_of(input logic [5:0] fld);
        case (fld)
            FLD_CFG:  return K_CFG;
            FLD_CMP:  return K_CMP;
            FLD_DSEL: return K_DSEL;
            FLD_MASK: return K_MASK;
            FLD_MOVE: return K_MOVE;
            FLD_STAT: return K_STAT;
            default:  return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cam_cmd_decode.sv
module cam_cmd_decode
    import cam_cmd_pkg::*;
#(
    parameter int OPC_W = 12
) (
    input  logic             cmd_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic             wr_n,
    output cmd_t             cmd
);
    localparam int HI_LSB = MSEL_LSB + MSEL_W;

    logic unused_top_bits;
    assign unused_top_bits = ^opcode[OPC_W-1:HI_LSB];

    always_comb begin
        cmd.kind  = cmd_valid ? kind_of(opcode[5:0]) : K_NONE;
        cmd.is_wr = ~wr_n;
        cmd.msel  = opcode[MSEL_LSB +: MSEL_W];
    end
endmodule

// File: rtl/cam_mask_bank.sv
module cam_mask_bank #(
    parameter int DATA_W = 32,
    parameter int NSEL   = 8,
    localparam int SEL_W = $clog2(NSEL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] sel_mask
);
    logic [NSEL-1:1][DATA_W-1:0] bank_q;

    generate
        for (genvar g = 1; g < NSEL; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)
                    bank_q[g] <= '0;
                else if (wr_en && sel == SEL_W'(g))
                    bank_q[g] <= wr_data;
            end
        end
    endgenerate

    // Code 0 selects no mask: every bit may change
    always_comb begin
        sel_mask = '0;
        for (int i = 1; i < NSEL; i++)
            if (sel == SEL_W'(i)) sel_mask = bank_q[i];
    end

    // R4
    mask_zero_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == '0) |=> $stable(bank_q));

    // R4
    mask_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel != '0) |=> sel_mask == $past(wr_data) || sel != $past(sel));
endmodule

// File: rtl/cam_word_store.sv
module cam_word_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid_bit
);
    logic [DATA_W-1:0] word_q [DEPTH];
    logic [DEPTH-1:0]  vbit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vbit_q <= '0;
            for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
        end else if (we) begin
            word_q[addr] <= wdata;
            vbit_q[addr] <= wvalid;
        end
    end

    assign rdata      = word_q[addr];
    assign rvalid_bit = vbit_q[addr];

    // R5
    move_valid_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> vbit_q[$past(addr)] == $past(wvalid));

    // R5
    move_word_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> word_q[$past(addr)] == $past(wdata));
endmodule

// File: rtl/cam_cmd_regfile.sv
module cam_cmd_regfile
    import cam_cmd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OPC_W  = 12,
    parameter int DEPTH  = 16,
    parameter int NMASK  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              vld_n_in,
    input  logic              addr_load,
    input  logic [AW-1:0]     addr_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    cmd_t              cmd;
    logic [DATA_W-1:0] cfg_q, cmp_q, dsel_q;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] sel_mask, mem_word, rd_mux;
    logic              mem_vbit, rd_hit;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    // Keep a bit of old where mask is 1, take new where mask is 0
    function automatic logic [DATA_W-1:0] blend(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [DATA_W-1:0] m);
        return (old_w & m) | (new_w & ~m);
    endfunction

    cam_cmd_decode #(.OPC_W(OPC_W)) dec_i (
        .cmd_valid(cmd_valid), .opcode(opcode), .wr_n(wr_n), .cmd(cmd));

    cam_mask_bank #(.DATA_W(DATA_W), .NSEL(NMASK)) masks_i (
        .clk(clk), .rst(rst),
        .wr_en(cmd.kind == K_MASK && cmd.is_wr),
        .sel(cmd.msel), .wr_data(data_in), .sel_mask(sel_mask));

    cam_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst),
        .we(cmd.kind == K_MOVE && cmd.is_wr),
        .addr(addr_q),
        .wdata(blend(mem_word, cmp_q, sel_mask)),
        .wvalid(~vld_n_in),
        .rdata(mem_word), .rvalid_bit(mem_vbit));

    always_comb begin
        rd_hit = 1'b0;
        rd_mux = '0;
        if (!cmd.is_wr) begin
            case (cmd.kind)
                K_CFG:  begin rd_hit = 1'b1; rd_mux = cfg_q;  end
                K_CMP:  begin rd_hit = 1'b1; rd_mux = cmp_q;  end
                K_DSEL: begin rd_hit = 1'b1; rd_mux = dsel_q; end
                K_STAT: begin rd_hit = 1'b1; rd_mux = {{(DATA_W-1){1'b0}}, mem_vbit}; end
                K_MASK: begin rd_hit = (cmd.msel != '0); rd_mux = sel_mask; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            cmp_q      <= '0;
            dsel_q     <= '0;
            addr_q     <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            if (addr_load) addr_q <= addr_in;
            if (cmd.is_wr) begin
                case (cmd.kind)
                    K_CFG:  cfg_q  <= blend(cfg_q,  data_in, sel_mask);
                    K_CMP:  cmp_q  <= blend(cmp_q,  data_in, sel_mask);
                    K_DSEL: dsel_q <= blend(dsel_q, data_in, sel_mask);
                    default: ;
                endcase
            end else if (cmd.kind == K_MOVE) begin
                cmp_q <= blend(cmp_q, mem_word, sel_mask);
            end
            rd_valid_q <= rd_hit;
            rd_data_q  <= rd_hit ? rd_mux : '0;
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    // R7
    rd_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(cmd_valid && wr_n));

    // R7
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(cfg_q) && $stable(cmp_q) && $stable(dsel_q) && !rd_valid);

    // R6
    move_out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == K_MOVE && !cmd.is_wr) |=> !rd_valid);

    // R10
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        addr_load |=> addr_q == $past(addr_in));
endmodule

// File: tb/cam_cmd_regfile_tb_top.sv
module cam_cmd_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [11:0]   opcode = '0;
    logic          wr_n = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          vld_n_in = 1'b1;
    logic          addr_load = 1'b0;
    logic [3:0]    addr_in = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    cam_cmd_regfile dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .opcode(opcode),
        .wr_n(wr_n), .data_in(data_in), .vld_n_in(vld_n_in),
        .addr_load(addr_load), .addr_in(addr_in),
        .rd_data(rd_data), .rd_valid(rd_valid));

    always #(CLK_PERIOD/2) clk = ~clk;

    int vecs = 0;
    int miss = 0;

    // Behavioural reference state
    logic [DW-1:0] m_cfg = '0, m_cmp = '0, m_ds = '0;
    logic [DW-1:0] m_mask [8];
    logic [DW-1:0] m_mem  [DEPTH];
    bit            m_vb   [DEPTH];
    logic [3:0]    m_addr = '0;
    bit            e_v = 1'b0;
    logic [DW-1:0] e_d = '0;
    string         e_tag = "R1";

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [DW-1:0] m);
        logic [DW-1:0] r;
        for (int b = 0; b < DW; b++) r[b] = m[b] ? old_w[b] : new_w[b];
        return r;
    endfunction

    task automatic model_reset();
        m_cfg = '0; m_cmp = '0; m_ds = '0; m_addr = '0; e_v = 0; e_d = '0;
        for (int i = 0; i < 8; i++) m_mask[i] = '0;
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_vb[i] = 0; end
    endtask

    task automatic model_step(input bit cv, input logic [11:0] op, input bit wrn,
                              input logic [DW-1:0] d, input bit vn,
                              input bit ld, input logic [3:0] a);
        int sel = op[8:6];
        logic [DW-1:0] mk = (sel == 0) ? '0 : m_mask[sel];
        e_v = 0; e_d = '0;
        if (cv) begin
            if (!wrn) begin
                case (op[5:0])
                    6'h06: m_cfg = merge(m_cfg, d, mk);
                    6'h05: m_cmp = merge(m_cmp, d, mk);
                    6'h08: m_ds  = merge(m_ds,  d, mk);
                    6'h09: if (sel != 0) m_mask[sel] = d;
                    6'h0C: begin m_mem[m_addr] = merge(m_mem[m_addr], m_cmp, mk); m_vb[m_addr] = !vn; end
                    default: ;
                endcase
            end else begin
                case (op[5:0])
                    6'h06: begin e_v = 1; e_d = m_cfg; end
                    6'h05: begin e_v = 1; e_d = m_cmp; end
                    6'h08: begin e_v = 1; e_d = m_ds;  end
                    6'h07: begin e_v = 1; e_d = {31'b0, m_vb[m_addr]}; end
                    6'h09: if (sel != 0) begin e_v = 1; e_d = m_mask[sel]; end
                    6'h0C: m_cmp = merge(m_cmp, m_mem[m_addr], mk);
                    default: ;
                endcase
            end
        end
        if (ld) m_addr = a;
    endtask

    task automatic compare();
        vecs++;
        if (rd_valid !== e_v || rd_data !== e_d) begin
            miss++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     e_tag, rd_valid, rd_data, e_v, e_d);
        end
    endtask

    task automatic apply(input bit cv, input logic [11:0] op, input bit wrn,
                         input logic [DW-1:0] d, input bit vn, input bit ld,
                         input logic [3:0] a, input string tag);
        @(negedge clk);
        compare();
        cmd_valid = cv; opcode = op; wr_n = wrn; data_in = d;
        vld_n_in = vn; addr_load = ld; addr_in = a;
        @(posedge clk);
        model_step(cv, op, wrn, d, vn, ld, a);
        e_tag = tag;
    endtask

    task automatic wr(input logic [5:0] f, input logic [2:0] s, input logic [DW-1:0] d, input string tag);
        apply(1, {3'b000, s, f}, 0, d, 1, 0, '0, tag);
    endtask

    task automatic rd(input logic [5:0] f, input logic [2:0] s, input string tag);
        apply(1, {3'b000, s, f}, 1, '0, 1, 0, '0, tag);
    endtask

    task automatic ld_addr(input logic [3:0] a, input string tag);
        apply(0, '0, 1, '0, 1, 1, a, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin : stim
        logic [5:0] fl [6] = '{6'h06, 6'h05, 6'h09, 6'h08, 6'h0C, 6'h07};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();                       // R1: outputs idle during reset
        rst = 1'b0;

        // R1: everything reads zero after reset
        rd(6'h06, 0, "R1"); rd(6'h05, 0, "R1"); rd(6'h08, 0, "R1"); rd(6'h07, 0, "R1");
        for (int k = 1; k < 8; k++) rd(6'h09, 3'(k), "R1");

        // R4: mask loads, code 0 stores nothing and reads nothing
        wr(6'h09, 1, 32'hFFFF_0000, "R4");
        wr(6'h09, 2, 32'h0F0F_0F0F, "R4");
        wr(6'h09, 7, 32'hAAAA_AAAA, "R4");
        wr(6'h09, 0, 32'h1234_5678, "R4");
        rd(6'h09, 0, "R4"); rd(6'h09, 1, "R4"); rd(6'h09, 2, "R4"); rd(6'h09, 7, "R4");
        rd(6'h09, 3, "R4");

        // R3: unmasked then masked writes
        wr(6'h06, 0, 32'hDEAD_BEEF, "R3");
        wr(6'h06, 1, 32'h1111_1111, "R3");
        rd(6'h06, 0, "R3");
        wr(6'h08, 2, 32'hFFFF_FFFF, "R3");
        rd(6'h08, 0, "R3");
        // R2: top opcode bits ignored
        apply(1, 12'b101_000_000101, 0, 32'hCAFE_F00D, 1, 0, '0, "R2");
        apply(1, 12'b111_000_000101, 1, '0, 1, 0, '0, "R2");
        apply(1, 12'b010_111_000101, 0, 32'h0000_0000, 1, 0, '0, "R2");
        rd(6'h05, 0, "R2");

        // R5/R10: move-in while pointer changes in the same cycle
        ld_addr(4'd3, "R10");
        apply(1, 12'h00C, 0, '0, 0, 1, 4'd5, "R10");
        rd(6'h07, 0, "R8");
        wr(6'h05, 0, 32'h5555_AAAA, "R5");
        apply(1, 12'h00C, 0, '0, 1, 0, '0, "R5");
        rd(6'h07, 0, "R5");
        ld_addr(4'd3, "R10");
        rd(6'h07, 0, "R8");
        // R8: status write has no effect
        wr(6'h07, 0, 32'hFFFF_FFFF, "R8");
        rd(6'h07, 0, "R8");

        // R6: masked move-out into the comparand
        wr(6'h05, 0, 32'h0123_4567, "R6");
        apply(1, {3'b000, 3'd7, 6'h0C}, 1, '0, 1, 0, '0, "R6");
        rd(6'h05, 0, "R6");
        apply(1, {3'b000, 3'd1, 6'h0C}, 0, '0, 0, 0, '0, "R5");
        apply(1, 12'h00C, 1, '0, 1, 0, '0, "R6");
        rd(6'h05, 0, "R6");

        // R9: unknown opcodes and idle cycles change nothing
        wr(6'h3F, 0, 32'hFFFF_FFFF, "R9");
        wr(6'h00, 0, 32'hFFFF_FFFF, "R9");
        rd(6'h2A, 0, "R9");
        apply(0, 12'h006, 0, 32'h9999_9999, 1, 0, '0, "R9");
        apply(0, 12'h006, 1, '0, 1, 0, '0, "R9");
        rd(6'h06, 0, "R9"); rd(6'h08, 0, "R9"); rd(6'h05, 0, "R9");

        // R7: random mix, compared every cycle
        for (int i = 0; i < 600; i++) begin
            logic [5:0] f = ($urandom_range(0, 7) < 6) ? fl[$urandom_range(0, 5)] : 6'($urandom);
            apply(($urandom_range(0, 9) != 0), {3'($urandom), 3'($urandom), f},
                  1'($urandom), $urandom, 1'($urandom), ($urandom_range(0, 3) == 0),
                  4'($urandom), "R7");
        end

        apply(0, '0, 1, '0, 1, 0, '0, "R7");
        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule